// File: doc/BRIEF.md
# Receive Interrupt Status Register

This block holds the receive-side status of a serial bus controller in one 8-bit register and turns it into a single interrupt line. Two of its flags follow live conditions: one shows that the receive FIFO holds data, and one shows that a message buffer has filled while its interrupt is enabled. These two flags set as soon as their condition appears. They drop only after the clearing condition has held for a fixed delay of two clock cycles. Five more flags record events: a sync pulse of alarm type, a sync pulse of normal type, a slot mismatch, an extra sync, and an optical diagnostic. Each of these stays set until software writes a 1 to its bit.

Software reads the register through a plain read port and clears flags through a write strobe. A separate 8-bit enable word, laid out like the status register, chooses which pending flags drive the combined interrupt output. The number of message buffers and the clear delay are parameters.

Top module: `rx_irq_status`

## Requirements
- R1: While reset is active and right after it, every status bit reads 0 and `irq_o` is 0.
- R2: Bit 7 (FIFO has data) is 1 from the clock edge after the first edge at which `fifo_nonempty_i` is sampled high. It stays 1 as long as the FIFO is not empty, whatever the buffer 0 lock state.
- R3: Bit 7 clears only after both conditions hold together: the FIFO is empty and `buf0_locked_i` is 0. It clears on the third consecutive edge at which both are sampled, so reads in the two cycles before that still return 1. If buffer 0 locks again, or data arrives, the count starts over.
- R4: Bit 6 (receive) sets one edge after some buffer has both its `buf_full_i` bit and its `buf_ien_i` bit at 1. A full buffer whose enable is 0 does not set it.
- R5: Bit 6 clears on the third consecutive edge at which no enabled buffer is full. While any enabled buffer is still full, it stays set.
- R6: A pulse on `evt_i` sets a sticky flag on the next edge, and the flag holds after the pulse ends. The mapping is: `evt_i[4]` sync alarm to bit 5, `evt_i[3]` sync normal to bit 4, `evt_i[2]` slot mismatch to bit 3, `evt_i[1]` extra sync to bit 1, `evt_i[0]` diagnostic to bit 0.
- R7: A write with a 1 in a sticky bit position clears that flag on the next edge. A 0 in that position leaves the flag as it was.
- R8: If an event and a write-1 clear hit the same sticky flag in the same cycle, the flag ends up set.
- R9: Writes have no effect on bits 7, 6 and 2. Bit 2 always reads 0.
- R10: `irq_o` is 1 exactly when some status bit and the same bit of `ien_i` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fifo_nonempty_i | input | 1 | Receive FIFO holds data |
| buf0_locked_i | input | 1 | Buffer 0 is locked |
| buf_full_i | input | NUM_BUF | Per-buffer full flags |
| buf_ien_i | input | NUM_BUF | Per-buffer interrupt enables |
| evt_i | input | 5 | Event pulses for the sticky flags |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data; a 1 clears a sticky flag |
| ien_i | input | 8 | Interrupt enables, same bit layout as the status |
| rd_data_o | output | 8 | Status register contents |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A sticky event and a software write-1 clear can fall on the same flag in the same clock cycle. The bench provokes this by pulsing one event input in the very cycle that writes 1 to that bit, with no gap between them. Its scoreboard expects the flag to read 1 after that edge and to clear only on a later write. The bench also restarts the two-cycle clear count of the FIFO flag by locking buffer 0 again in the middle of the count, and checks the exact edge at which the flag then drops.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;
   localparam int REG_W     = 8;
   localparam int STICKY_N  = 5;
   localparam int B_FIFO    = 7;
   localparam int B_RX      = 6;
   localparam int B_SALARM  = 5;
   localparam int B_SNORM   = 4;
   localparam int B_SLOT    = 3;
   localparam int B_RSVD    = 2;
   localparam int B_XSYNC   = 1;
   localparam int B_DIAG    = 0;

   // sticky vector order: [4] alarm, [3] normal, [2] slot, [1] extra sync, [0] diag
   function automatic logic [STICKY_N-1:0] pick_sticky(input logic [REG_W-1:0] v);
      return {v[B_SALARM], v[B_SNORM], v[B_SLOT], v[B_XSYNC], v[B_DIAG]};
   endfunction
endpackage

// File: rtl/rx_live_flag.sv
module rx_live_flag #(
   parameter int CLR_DELAY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;
   assign flag_o = flag_q;

   generate
      if (CLR_DELAY < 0) begin : g_bad_delay
         $error("rx_live_flag: CLR_DELAY must not be negative");
      end
      if (CLR_DELAY == 0) begin : g_immediate
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     flag_q <= 1'b0;
            else if (set_i) flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
         end
      end else begin : g_delayed
         localparam int CNT_W = (CLR_DELAY < 2) ? 1 : $clog2(CLR_DELAY + 1);
         localparam logic [CNT_W-1:0] CNT_END = CNT_W'(CLR_DELAY);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_q <= 1'b0;
               cnt_q  <= '0;
            end else if (set_i) begin
               flag_q <= 1'b1;
               cnt_q  <= '0;
            end else if (clr_i) begin
               if (cnt_q == CNT_END) flag_q <= 1'b0;
               else                  cnt_q  <= cnt_q + 1'b1;
            end else begin
               cnt_q <= '0;
            end
         end

         // R3 / R5: no clear before the delay has run out
         p_early_hold_r3_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q && !set_i && cnt_q != CNT_END) |=> flag_q);
      end
   endgenerate

   // R2 / R4: a live condition sets the flag on the next edge
   p_set_follows_r2_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);

   // R3 / R5: the flag only falls while its clear condition is present
   p_fall_cause_r3_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> $past(clr_i));
endmodule

// File: rtl/rx_sticky_bank.sv
module rx_sticky_bank #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("rx_sticky_bank: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= 1'b0;
            else if (evt_i[i]) q <= 1'b1;
            else if (clr_i[i]) q <= 1'b0;
         end
         assign q_o[i] = q;

         p_evt_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> q_o[i]);
         p_wclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !evt_i[i]) |=> !q_o[i]);
         p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (q_o[i] && !clr_i[i]) |=> q_o[i]);
         p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[i] && clr_i[i]) |=> q_o[i]);
      end
   endgenerate
endmodule

// File: rtl/rx_irq_status.sv
module rx_irq_status
   import rx_irq_pkg::*;
#(
   parameter int NUM_BUF   = 16,
   parameter int CLR_DELAY = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fifo_nonempty_i,
   input  logic               buf0_locked_i,
   input  logic [NUM_BUF-1:0] buf_full_i,
   input  logic [NUM_BUF-1:0] buf_ien_i,
   input  logic [4:0]         evt_i,
   input  logic               wr_en_i,
   input  logic [7:0]         wr_data_i,
   input  logic [7:0]         ien_i,
   output logic [7:0]         rd_data_o,
   output logic               irq_o
);
   generate
      if (NUM_BUF < 1) begin : g_bad_buf
         $error("rx_irq_status: NUM_BUF must be at least 1");
      end
   endgenerate

   logic fifo_flag, rx_flag, any_full;
   logic [STICKY_N-1:0] sticky_q, sticky_clr;
   logic [REG_W-1:0] status;

   assign any_full   = |(buf_full_i & buf_ien_i);
   assign sticky_clr = wr_en_i ? pick_sticky(wr_data_i) : '0;

   rx_live_flag #(.CLR_DELAY(CLR_DELAY)) u_fifo_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (fifo_nonempty_i),
      .clr_i  (!fifo_nonempty_i && !buf0_locked_i),
      .flag_o (fifo_flag)
   );

   rx_live_flag #(.CLR_DELAY(CLR_DELAY)) u_rx_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (any_full),
      .clr_i  (!any_full),
      .flag_o (rx_flag)
   );

   rx_sticky_bank #(.N(STICKY_N)) u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (evt_i),
      .clr_i (sticky_clr),
      .q_o   (sticky_q)
   );

   always_comb begin
      status           = '0;
      status[B_FIFO]   = fifo_flag;
      status[B_RX]     = rx_flag;
      status[B_SALARM] = sticky_q[4];
      status[B_SNORM]  = sticky_q[3];
      status[B_SLOT]   = sticky_q[2];
      status[B_RSVD]   = 1'b0;
      status[B_XSYNC]  = sticky_q[1];
      status[B_DIAG]   = sticky_q[0];
   end

   assign rd_data_o = status;
   assign irq_o     = |(status & ien_i);

   // R9: a write alone cannot drop the FIFO flag while buffer 0 stays locked
   p_ro_fifo_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_o[B_FIFO] && wr_en_i && buf0_locked_i) |=> rd_data_o[B_FIFO]);
   // R9: a write alone cannot drop the receive flag while a buffer is full
   p_ro_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_o[B_RX] && wr_en_i && any_full) |=> rd_data_o[B_RX]);
endmodule

// File: tb/sim_rx_irq_status.sv
`timescale 1ns/1ps
module sim_rx_irq_status;
   localparam int NB = 16;

   typedef struct {
      logic [7:0] rd;
      logic       irq;
      string      tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fne = 1'b0, locked = 1'b1, we = 1'b0;
   logic [NB-1:0] full = '0, bena = '0;
   logic [4:0]    ev = '0;
   logic [7:0]    wd = '0, ien = '0;
   logic [7:0]    rd;
   logic          irq;

   int n_checks = 0, n_fail = 0;
   item_t q[$];

   // model state
   logic mf = 1'b0, mr = 1'b0;
   int   mfc = 0, mrc = 0;
   logic [4:0] ms = '0;

   always #4 clk = ~clk;

   rx_irq_status #(.NUM_BUF(NB), .CLR_DELAY(2)) u0 (
      .clk(clk), .rst_n(rst_n), .fifo_nonempty_i(fne), .buf0_locked_i(locked),
      .buf_full_i(full), .buf_ien_i(bena), .evt_i(ev), .wr_en_i(we),
      .wr_data_i(wd), .ien_i(ien), .rd_data_o(rd), .irq_o(irq));

   task automatic check(input logic [7:0] a_rd, input logic a_irq, input item_t e);
      n_checks++;
      if (a_rd !== e.rd || a_irq !== e.irq) begin
         n_fail++;
         $display("FAIL %s: rd=%02h irq=%0b expected rd=%02h irq=%0b",
                  e.tag, a_rd, a_irq, e.rd, e.irq);
      end
   endtask

   // driver: applies one cycle of stimulus and pushes the expected state after the edge
   task automatic step(input logic f, input logic l, input logic [NB-1:0] fu,
                       input logic [NB-1:0] en, input logic [4:0] e,
                       input logic w, input logic [7:0] d, input logic [7:0] ie,
                       input string tag);
      item_t it;
      logic [4:0] wclr;
      fne = f; locked = l; full = fu; bena = en; ev = e; we = w; wd = d; ien = ie;
      if (f) begin mf = 1'b1; mfc = 0; end
      else if (!l) begin if (mfc >= 2) mf = 1'b0; else mfc++; end
      else mfc = 0;
      if (|(fu & en)) begin mr = 1'b1; mrc = 0; end
      else begin if (mrc >= 2) mr = 1'b0; else mrc++; end
      wclr = w ? {d[5], d[4], d[3], d[1], d[0]} : 5'b0;
      for (int i = 0; i < 5; i++) begin
         if (e[i]) ms[i] = 1'b1;
         else if (wclr[i]) ms[i] = 1'b0;
      end
      it.rd  = {mf, mr, ms[4], ms[3], ms[2], 1'b0, ms[1], ms[0]};
      it.irq = |(it.rd & ie);
      it.tag = tag;
      q.push_back(it);
      @(negedge clk);
   endtask

   // monitor: compares after each edge
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         check(rd, irq, it);
      end
   end

   bit done = 0;
   initial begin
      #(200000 * 8);
      if (!done) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      item_t r;
      repeat (3) @(negedge clk);
      r.rd = 8'h00; r.irq = 1'b0; r.tag = "R1 in reset";
      check(rd, irq, r);
      rst_n = 1'b1;
      @(negedge clk);
      r.tag = "R1 after reset";
      check(rd, irq, r);

      // R2: FIFO flag sets and holds while not empty
      step(1, 1, '0, '0, '0, 0, '0, 8'h00, "R2 set locked");
      step(1, 1, '0, '0, '0, 0, '0, 8'h80, "R2 hold irq");
      step(1, 0, '0, '0, '0, 0, '0, 8'h80, "R2 unlocked nonempty");
      step(1, 0, '0, '0, '0, 0, '0, 8'h80, "R2 unlocked nonempty 2");
      // R3: held while empty but locked
      step(0, 1, '0, '0, '0, 0, '0, 8'h80, "R3 empty locked");
      step(0, 1, '0, '0, '0, 0, '0, 8'h80, "R3 empty locked 2");
      step(0, 1, '0, '0, '0, 0, '0, 8'h80, "R3 empty locked 3");
      // R3: count restarts on relock
      step(0, 0, '0, '0, '0, 0, '0, 8'h80, "R3 count 1");
      step(0, 1, '0, '0, '0, 0, '0, 8'h80, "R3 relock");
      step(0, 0, '0, '0, '0, 0, '0, 8'h80, "R3 restart 1");
      step(0, 0, '0, '0, '0, 0, '0, 8'h80, "R3 restart 2");
      step(0, 0, '0, '0, '0, 0, '0, 8'h80, "R3 cleared");
      step(0, 0, '0, '0, '0, 0, '0, 8'h80, "R3 stays clear");

      // R4: disabled full buffer ignored
      step(0, 1, 16'h0008, 16'h0000, '0, 0, '0, 8'h40, "R4 disabled full");
      step(0, 1, 16'h0008, 16'h0000, '0, 0, '0, 8'h40, "R4 disabled full 2");
      step(0, 1, 16'h8008, 16'h8008, '0, 0, '0, 8'h40, "R4 enabled full");
      step(0, 1, 16'h8000, 16'h8008, '0, 0, '0, 8'h40, "R5 one still full");
      step(0, 1, 16'h8000, 16'h8008, '0, 0, '0, 8'h40, "R5 one still full 2");
      step(0, 1, 16'h0000, 16'h8008, '0, 0, '0, 8'h40, "R5 delay 1");
      step(0, 1, 16'h0000, 16'h8008, '0, 0, '0, 8'h40, "R5 delay 2");
      step(0, 1, 16'h0000, 16'h8008, '0, 0, '0, 8'h40, "R5 cleared");

      // R6: sticky events
      step(0, 1, '0, '0, 5'b10000, 0, '0, 8'h00, "R6 alarm pulse");
      step(0, 1, '0, '0, 5'b00000, 0, '0, 8'h20, "R6 alarm held");
      step(0, 1, '0, '0, 5'b00111, 0, '0, 8'h00, "R6 slot xsync diag");
      step(0, 1, '0, '0, 5'b01000, 0, '0, 8'h10, "R6 normal");
      // R7: write 0 no change, write 1 clears
      step(0, 1, '0, '0, '0, 1, 8'h00, 8'h3B, "R7 write zeros");
      step(0, 1, '0, '0, '0, 1, 8'h20, 8'h20, "R7 clear alarm");
      step(0, 1, '0, '0, '0, 1, 8'h09, 8'h3B, "R7 clear slot diag");
      // R8: event wins against clear in same cycle
      step(0, 1, '0, '0, 5'b01000, 1, 8'h10, 8'h10, "R8 normal event vs clear");
      step(0, 1, '0, '0, '0, 0, '0, 8'h10, "R8 normal still set");
      step(0, 1, '0, '0, '0, 1, 8'h3B, 8'hFF, "R7 clear all sticky");

      // R9: writes cannot touch bits 7, 6, 2
      step(1, 1, 16'h0001, 16'h0001, '0, 0, '0, 8'h00, "R9 setup");
      step(1, 1, 16'h0001, 16'h0001, '0, 1, 8'hFF, 8'h00, "R9 write ones");
      step(1, 1, 16'h0001, 16'h0001, '0, 1, 8'hC4, 8'h04, "R9 write ro bits");
      // R10: irq gating
      step(1, 1, 16'h0001, 16'h0001, 5'b00001, 0, '0, 8'h00, "R10 none enabled");
      step(1, 1, 16'h0001, 16'h0001, '0, 0, '0, 8'h01, "R10 diag enabled");
      step(1, 1, 16'h0001, 16'h0001, '0, 1, 8'h01, 8'h3F, "R10 sticky cleared rx on");
      step(1, 1, 16'h0001, 16'h0001, '0, 0, '0, 8'h3B, "R10 only disabled pending");

      while (q.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule